// File: doc/BRIEF.md
# Dual-Channel Frozen-Angle Byte Readout

This block is the host-facing readout stage for two independent angle trackers. Each tracker feeds a live angle word of up to 16 bits. The host pulls one shared active-low hold line low before a read. While the line is low, each channel keeps a snapshot of its angle. The trackers upstream keep running, and releasing the hold line lets each snapshot follow its live angle again.

The host reads a snapshot one byte at a time over one shared 8-bit bus. There are four active-low byte selects: upper and lower byte for channel A, and upper and lower byte for channel B. The hold line and the selects each pass through a short clock-synchronous pipeline of parameterised depth. These pipelines model the bounded settle delay after the hold line falls and after a select falls.

If several selects are active together, a fixed priority picks the byte that is driven, and a collision flag goes high. The pad tri-state drivers are outside this block. It provides the byte value and an output-enable for them.

Top module: `angle_bytebus`

## Requirements
- R1: While reset is asserted, bus_oe and collide are 0 and bus_data is 8'h00.
- R2: While inh_n is high, the snapshot of each channel follows its live angle. A steady angle is visible on the bus one clock after the hold pipeline reports "not held".
- R3: After inh_n falls, each snapshot takes the angle present at the INH_DLY-th rising clock edge. Angle changes after that edge are ignored for as long as inh_n stays low.
- R4: After inh_n rises, a persistently selected byte still shows the held value after INH_DLY rising edges. It shows the current live angle after INH_DLY+1 rising edges.
- R5: An active upper-byte select drives the top 8 bits of that channel's angle. Angle MSB appears on bus_data[7].
- R6: An active lower-byte select drives the remaining low-order bits left-justified. With ANGLE_W=16 this is angle[7:0]. With ANGLE_W=14 it is angle[5:0] on bus_data[7:2], and bus_data[1:0] read 0.
- R7: With all four selects high, bus_oe is 0 and bus_data is 8'h00.
- R8: bus_oe rises exactly EN_DLY rising edges after a select falls. It falls exactly EN_DLY rising edges after the last select rises.
- R9: With two or more selects active, the driven byte follows the priority A-upper > A-lower > B-upper > B-lower, and collide is 1.
- R10: With exactly one select active, collide is 0.
- R11: Channel B bytes come only from channel B's angle, and channel A bytes come only from channel A's angle. The single hold line freezes both channels at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ang_a | input | ANGLE_W | Live angle of channel A |
| ang_b | input | ANGLE_W | Live angle of channel B |
| inh_n | input | 1 | Shared active-low hold; low freezes both snapshots |
| en_hi_a_n | input | 1 | Active-low select, channel A upper byte |
| en_lo_a_n | input | 1 | Active-low select, channel A lower byte |
| en_hi_b_n | input | 1 | Active-low select, channel B upper byte |
| en_lo_b_n | input | 1 | Active-low select, channel B lower byte |
| bus_data | output | 8 | Byte for the shared bus; 0 when not driven |
| bus_oe | output | 1 | Output-enable for the pad drivers |
| collide | output | 1 | More than one select active |

## Verification
The bench changes the angle exactly one cycle before, and then exactly at, the freezing edge. A design that freezes one edge early or late therefore returns the wrong one of two distinct values. It keeps one select asserted across a hold release and samples on each side of the edge where tracking resumes. This catches a snapshot that stays stuck, or one that resumes too soon.

A second instance built for 14 bits shows whether the short low byte is left-justified with zero padding. A misaligned implementation would put angle bits on the wrong lines. Random select patterns with several selects active expose a wrong priority order or a collision flag that stays silent.

// File: rtl/angle_bus_pkg.sv
package angle_bus_pkg;

  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned WORD_W  = 16;

  typedef enum logic [1:0] {
    SRC_A_HI = 2'd0,
    SRC_A_LO = 2'd1,
    SRC_B_HI = 2'd2,
    SRC_B_LO = 2'd3
  } src_e;

  // top 8 bits of a right-aligned word of 'bits' significant bits
  function automatic logic [7:0] upper_byte(input logic [WORD_W-1:0] w,
                                            input int unsigned bits);
    logic [WORD_W-1:0] sh;
    sh = w >> (bits - 8);
    return sh[7:0];
  endfunction

  // remaining low bits, left-justified on the byte, zero padded below
  function automatic logic [7:0] lower_byte(input logic [WORD_W-1:0] w,
                                            input int unsigned bits);
    logic [WORD_W-1:0] sh;
    sh = w << (WORD_W - bits);
    return sh[7:0];
  endfunction

endpackage

// File: rtl/sync_pipe.sv
module sync_pipe #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned DEPTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [WIDTH-1:0] stage [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_st
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage[i] <= RST_VAL;
          end else if (i == 0) begin
            stage[i] <= d;
          end else begin
            stage[i] <= stage[(i == 0) ? 0 : i-1];
          end
        end
      end
      assign q = stage[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/angle_hold.sv
module angle_hold #(
  parameter int unsigned ANGLE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               freeze,
  input  logic [ANGLE_W-1:0] live,
  output logic [ANGLE_W-1:0] held
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (!freeze) begin
      held <= live;
    end
  end

endmodule

// File: rtl/byte_arbiter.sv
module byte_arbiter
  import angle_bus_pkg::*;
#(
  parameter int unsigned ANGLE_W = 16
) (
  input  logic [NUM_SRC-1:0] en_act,
  input  logic [WORD_W-1:0]  word_a,
  input  logic [WORD_W-1:0]  word_b,
  output logic [7:0]         data,
  output logic               oe,
  output logic               collide,
  output src_e               sel
);

  always_comb begin
    sel = SRC_A_HI;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (en_act[i]) sel = src_e'(i);
    end
  end

  assign oe      = |en_act;
  assign collide = $countones(en_act) > 1;

  always_comb begin
    data = 8'h00;
    if (oe) begin
      unique case (sel)
        SRC_A_HI: data = upper_byte(word_a, ANGLE_W);
        SRC_A_LO: data = lower_byte(word_a, ANGLE_W);
        SRC_B_HI: data = upper_byte(word_b, ANGLE_W);
        SRC_B_LO: data = lower_byte(word_b, ANGLE_W);
        default:  data = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/angle_bytebus.sv
module angle_bytebus
  import angle_bus_pkg::*;
#(
  parameter int unsigned ANGLE_W = 16,
  parameter int unsigned INH_DLY = 2,
  parameter int unsigned EN_DLY  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ANGLE_W-1:0] ang_a,
  input  logic [ANGLE_W-1:0] ang_b,
  input  logic               inh_n,
  input  logic               en_hi_a_n,
  input  logic               en_lo_a_n,
  input  logic               en_hi_b_n,
  input  logic               en_lo_b_n,
  output logic [7:0]         bus_data,
  output logic               bus_oe,
  output logic               collide
);

  localparam int unsigned NCH = 2;

  logic               inh_q;
  logic               freeze;
  logic [NUM_SRC-1:0] en_raw;
  logic [NUM_SRC-1:0] en_act;
  logic [ANGLE_W-1:0] live  [NCH];
  logic [ANGLE_W-1:0] held  [NCH];
  logic [ANGLE_W-1:0] held_a;
  logic [ANGLE_W-1:0] held_b;
  src_e               sel;

  sync_pipe #(.WIDTH(1), .DEPTH(INH_DLY), .RST_VAL(1'b1)) u_inh_pipe (
    .clk(clk), .rst_n(rst_n), .d(inh_n), .q(inh_q)
  );
  assign freeze = ~inh_q;

  assign en_raw = ~{en_lo_b_n, en_hi_b_n, en_lo_a_n, en_hi_a_n};

  sync_pipe #(.WIDTH(NUM_SRC), .DEPTH(EN_DLY), .RST_VAL('0)) u_en_pipe (
    .clk(clk), .rst_n(rst_n), .d(en_raw), .q(en_act)
  );

  assign live[0] = ang_a;
  assign live[1] = ang_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    angle_hold #(.ANGLE_W(ANGLE_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .freeze(freeze),
      .live(live[c]), .held(held[c])
    );
  end

  assign held_a = held[0];
  assign held_b = held[1];

  byte_arbiter #(.ANGLE_W(ANGLE_W)) u_arb (
    .en_act(en_act),
    .word_a(WORD_W'(held_a)),
    .word_b(WORD_W'(held_b)),
    .data(bus_data),
    .oe(bus_oe),
    .collide(collide),
    .sel(sel)
  );

endmodule

// File: rtl/angle_bytebus_chk.sv
module angle_bytebus_chk
  import angle_bus_pkg::*;
#(
  parameter int unsigned ANGLE_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               freeze,
  input logic [ANGLE_W-1:0] live_a,
  input logic [ANGLE_W-1:0] live_b,
  input logic [ANGLE_W-1:0] held_a,
  input logic [ANGLE_W-1:0] held_b,
  input logic [NUM_SRC-1:0] en_act,
  input logic [7:0]         bus_data,
  input logic               bus_oe,
  input logic               collide
);

  p_hold_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(held_a));

  p_hold_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(held_b));

  p_follow_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> held_a == $past(live_a));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_data == 8'h00);

  p_collide_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> bus_oe);

  p_a_upper_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_act[0] |-> bus_data == upper_byte(WORD_W'(held_a), ANGLE_W));

  p_single_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_act) |-> !collide);

endmodule

bind angle_bytebus angle_bytebus_chk #(.ANGLE_W(ANGLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze(freeze),
  .live_a(ang_a), .live_b(ang_b), .held_a(held_a), .held_b(held_b),
  .en_act(en_act), .bus_data(bus_data), .bus_oe(bus_oe), .collide(collide)
);

// File: tb/tb_angle_bytebus.sv
module tb_angle_bytebus;

  localparam int INH_D = 2;
  localparam int EN_D  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ang_a = '0, ang_b = '0;
  logic        inh_n = 1'b1;
  logic [3:0]  en_n = 4'hF;   // {lo_b, hi_b, lo_a, hi_a}
  logic [7:0]  d16, d14;
  logic        oe16, oe14, col16, col14;
  int          n_chk = 0, n_bad = 0;

  always #10ns clk = ~clk;

  angle_bytebus #(.ANGLE_W(16), .INH_DLY(INH_D), .EN_DLY(EN_D)) dut (
    .clk(clk), .rst_n(rst_n), .ang_a(ang_a), .ang_b(ang_b), .inh_n(inh_n),
    .en_hi_a_n(en_n[0]), .en_lo_a_n(en_n[1]), .en_hi_b_n(en_n[2]),
    .en_lo_b_n(en_n[3]), .bus_data(d16), .bus_oe(oe16), .collide(col16)
  );

  angle_bytebus #(.ANGLE_W(14), .INH_DLY(INH_D), .EN_DLY(EN_D)) dut14 (
    .clk(clk), .rst_n(rst_n), .ang_a(ang_a[13:0]), .ang_b(ang_b[13:0]),
    .inh_n(inh_n), .en_hi_a_n(en_n[0]), .en_lo_a_n(en_n[1]),
    .en_hi_b_n(en_n[2]), .en_lo_b_n(en_n[3]), .bus_data(d14),
    .bus_oe(oe14), .collide(col14)
  );

  function automatic logic [7:0] ref_byte(int w, logic [15:0] v, bit hi);
    logic [15:0] m;
    m = v & ((w == 16) ? 16'hFFFF : 16'h3FFF);
    if (hi) return m[w-1 -: 8];
    if (w == 16) return m[7:0];
    return {m[5:0], 2'b00};
  endfunction

  // returns {collide, oe, data}
  function automatic logic [9:0] ref_bus(int w, logic [15:0] a, logic [15:0] b,
                                         logic [3:0] en);
    int act;
    logic [7:0] d;
    act = 0;
    for (int i = 0; i < 4; i++) if (!en[i]) act++;
    if (!en[0])      d = ref_byte(w, a, 1);
    else if (!en[1]) d = ref_byte(w, a, 0);
    else if (!en[2]) d = ref_byte(w, b, 1);
    else if (!en[3]) d = ref_byte(w, b, 0);
    else             d = 8'h00;
    return {act > 1, act > 0, d};
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(logic [3:0] en, logic [15:0] ea, logic [15:0] eb, string req);
    logic [9:0] e16, e14;
    en_n = en;
    repeat (EN_D) @(negedge clk);
    e16 = ref_bus(16, ea, eb, en);
    e14 = ref_bus(14, ea, eb, en);
    chk(req, {6'd0, col16, oe16, d16}, {6'd0, e16});
    chk(req, {6'd0, col14, oe14, d14}, {6'd0, e14});
    en_n = 4'hF;
    repeat (EN_D) @(negedge clk);
  endtask

  initial begin : main
    logic [15:0] x, m, nv, a2, b2;
    process::self().srandom(32'h5EED_0017);
    repeat (2) @(negedge clk);
    chk("R1 reset", {13'd0, col16, oe16, d16 != 0}, 16'd0);
    chk("R1 reset 14b", {13'd0, col14, oe14, d14 != 0}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 idle
    chk("R7 idle", {7'd0, oe16, d16}, 16'd0);

    // R5/R6 directed
    ang_a = 16'hA5C3; ang_b = 16'h3C96;
    repeat (2) @(negedge clk);
    rd(4'b1110, ang_a, ang_b, "R5 upper A");
    rd(4'b1101, ang_a, ang_b, "R6 lower A");
    rd(4'b1011, ang_a, ang_b, "R11 upper B");
    rd(4'b0111, ang_a, ang_b, "R6 lower B");

    // R8 latency rise and fall
    en_n = 4'b1110;
    repeat (EN_D - 1) @(negedge clk);
    chk("R8 not yet", {15'd0, oe16}, 16'd0);
    @(negedge clk);
    chk("R8 on", {15'd0, oe16}, 16'd1);
    en_n = 4'hF;
    repeat (EN_D - 1) @(negedge clk);
    chk("R8 still on", {15'd0, oe16}, 16'd1);
    @(negedge clk);
    chk("R8 off", {15'd0, oe16}, 16'd0);

    // R3 freeze edge: value at the INH_D-th edge is kept
    x = 16'h1111; m = 16'h8E71; nv = 16'h7F02;
    ang_a = x; ang_b = ~x;
    repeat (2) @(negedge clk);
    inh_n = 1'b0;
    repeat (INH_D - 1) @(negedge clk);
    ang_a = m; ang_b = ~m;
    @(negedge clk);
    ang_a = nv; ang_b = ~nv;
    repeat (3) @(negedge clk);
    rd(4'b1110, m, ~m, "R3 held upper A");
    rd(4'b1101, m, ~m, "R3 held lower A");
    rd(4'b1011, m, ~m, "R11 held upper B");
    ang_a = 16'h0000;
    rd(4'b1110, m, ~m, "R3 change ignored");

    // R4 release with a persistent select
    ang_a = nv;
    en_n = 4'b1110;
    repeat (EN_D) @(negedge clk);
    inh_n = 1'b1;
    repeat (INH_D) @(negedge clk);
    chk("R4 still held", {8'd0, d16}, {8'd0, ref_byte(16, m, 1)});
    @(negedge clk);
    chk("R4 resumed", {8'd0, d16}, {8'd0, ref_byte(16, nv, 1)});
    en_n = 4'hF;
    repeat (EN_D) @(negedge clk);

    // R2 live follow
    ang_a = 16'h4D2B;
    @(negedge clk);
    rd(4'b1101, 16'h4D2B, ang_b, "R2 live");

    // R9/R10 random mix
    for (int it = 0; it < 200; it++) begin
      a2 = 16'($urandom); b2 = 16'($urandom);
      ang_a = a2; ang_b = b2;
      repeat (2) @(negedge clk);
      if ($urandom_range(0, 3) == 0) begin
        inh_n = 1'b0;
        repeat (INH_D) @(negedge clk);
        ang_a = 16'($urandom); ang_b = 16'($urandom);
        @(negedge clk);
        rd(4'($urandom), a2, b2, "R3 R9 random held");
        inh_n = 1'b1;
        repeat (INH_D + 1) @(negedge clk);
        a2 = ang_a; b2 = ang_b;
      end
      rd(4'($urandom), a2, b2, "R9 R10 random");
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule